// File: doc/BRIEF.md
# Clock-Run Keep-Alive Controller

This block sits on the device side of a clock-run handshake. The host asks to stop the shared bus clock by releasing the clock-run line. The block then decides whether to let the clock stop. If any activity still needs the clock, the block refuses by pulling the line back to its asserted level for a short, fixed time. If nothing needs the clock, the block lets the host stop it and records that the clock is parked. While the clock is parked, the block watches the card sockets and the internal datapath. When work shows up, it pulls the line to ask the host to restart the clock.

The block gathers activity from several places: per-socket card interrupts, per-socket status-change and wake events, card clock-start and bus requests, the state of each socket's card clock, FIFO occupancy, posted writes, a busy master and pending interrupts. Status-change and wake events are edge events. Each one is caught on its rising edge and held until a refusal or a wake request services it. The line output `crun_pull` means "drive the line low". The board-level open-drain wiring is outside the block.

Top module: `ckrun_keepalive`

## Requirements
- R1: After reset, `crun_pull` is 0, and the block is in the running state. In this state a released line is read as a stop request.
- R2: Suppose the line is sampled high (stop request) at clock edge k while the block is running. If master busy, posted write or any FIFO flag is set, `crun_pull` is 1 after edge k and after edge k+1, and 0 after edge k+2.
- R3: A pending interrupt, or any socket whose card clock is still running, causes the same two-cycle refusal as R2.
- R4: While `keep_clk` is 1, the clock never stays stopped. A stop request is refused. If `keep_clk` is set while the clock is parked, a restart request follows.
- R5: A stop request that finds no activity source set is accepted. The block parks, and `crun_pull` stays 0.
- R6: Suppose the clock is parked and a level source (any card interrupt of either kind, card clock request, card bus request, master busy, posted write, FIFO flag, pending interrupt or `keep_clk`) is first sampled at edge m. Then `crun_pull` is 1 after edges m+1 and m+2, and 0 after edge m+3.
- R7: While parked, a rising edge on any socket's status-change or wake input wakes the clock with the timing of R6, even if the input is high for only one cycle.
- R8: A status-change or wake rising edge that arrives while the clock runs stays latched. It causes the next stop request to be refused. The refusal clears the latch, so the stop request after that is accepted.
- R9: While parked, a running card clock on its own does not cause a restart request.
- R10: While parked, if the host drives the line low again, the block returns to the running state without pulling the line.
- R11: While the line is low and `crun_pull` is 0, `crun_pull` stays 0 at the next edge. This holds even when activity sources are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crun_line_n | input | 1 | Sampled clock-run line, 0 = asserted (clock wanted) |
| crun_pull | output | 1 | 1 = drive the clock-run line low |
| ireq16 | input | N_SOCK | 16-bit card interrupt request per socket |
| cint | input | N_SOCK | CardBus card interrupt per socket |
| stschg16 | input | N_SOCK | 16-bit card status-change / ring event per socket (edge) |
| cbwake | input | N_SOCK | CardBus wake / status-change event per socket (edge) |
| cclk_req | input | N_SOCK | Card requests its clock to be started |
| cbus_req | input | N_SOCK | Card requests the card bus |
| cclk_running | input | N_SOCK | Card-side clock of the socket is still running |
| keep_clk | input | 1 | Control bit: never allow the clock to stop |
| fifo_busy | input | N_FIFO | FIFO holds data, one flag per FIFO |
| post_pending | input | 1 | Posted write from card side not yet drained |
| master_busy | input | 1 | Master state machine is busy |
| irq_pending | input | 1 | Interrupt pending |

## Verification
A refusal and the servicing of an edge event can fall in the same cycle. This happens when a status-change or wake input rises on the very edge that samples the host's stop request. The bench raises such events together with the stop request in its random trials. It checks that the request is refused, and that the next stop request is accepted, so the latch was cleared rather than left set. A wake request and the host's own restart can also meet in one parked cycle. The bench covers this by giving the line back to the host while level sources are set. It judges the result by `crun_pull` staying low.

// File: rtl/ckrun_pkg.sv
package ckrun_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_REFUSE = 2'd1,
    ST_PARK   = 2'd2,
    ST_WAKE   = 2'd3
  } ckrun_state_e;
endpackage

// File: rtl/ckrun_rst_sync.sv
module ckrun_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/ckrun_evt_latch.sv
module ckrun_evt_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         service,
  output logic [W-1:0] rise,
  output logic [W-1:0] lat
);
  logic [W-1:0] prev_q;
  logic [W-1:0] lat_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i]  = evt[i] & ~prev_q[i];
    assign lat_d[i] = service ? 1'b0 : (lat[i] | rise[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat    <= '0;
    end else begin
      prev_q <= evt;
      lat    <= lat_d;
    end
  end
endmodule

// File: rtl/ckrun_fsm.sv
module ckrun_fsm
  import ckrun_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic hold_now,
  input  logic wake_now,
  output logic pull,
  output logic service
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  ckrun_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          wake_q;
  logic          pull_q, pull_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    service = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (line_n) begin
          if (hold_now) begin
            st_d    = ST_REFUSE;
            cnt_d   = '0;
            cnt_en  = 1'b1;
            service = 1'b1;
          end else begin
            st_d = ST_PARK;
          end
        end
      end
      ST_PARK: begin
        if (!line_n) begin
          st_d = ST_RUN;
        end else if (wake_q) begin
          st_d    = ST_WAKE;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          service = 1'b1;
        end
      end
      ST_REFUSE, ST_WAKE: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) st_d = ST_RUN;
        else               cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_RUN;
    endcase
    pull_d = (st_d == ST_REFUSE) || (st_d == ST_WAKE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      wake_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= wake_now;
      pull_q <= pull_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pull = pull_q;
endmodule

// File: rtl/ckrun_keepalive.sv
module ckrun_keepalive #(
  parameter int N_SOCK   = 2,
  parameter int N_FIFO   = 4,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crun_line_n,
  output logic              crun_pull,
  input  logic [N_SOCK-1:0] ireq16,
  input  logic [N_SOCK-1:0] cint,
  input  logic [N_SOCK-1:0] stschg16,
  input  logic [N_SOCK-1:0] cbwake,
  input  logic [N_SOCK-1:0] cclk_req,
  input  logic [N_SOCK-1:0] cbus_req,
  input  logic [N_SOCK-1:0] cclk_running,
  input  logic              keep_clk,
  input  logic [N_FIFO-1:0] fifo_busy,
  input  logic              post_pending,
  input  logic              master_busy,
  input  logic              irq_pending
);
  localparam int EV_W = 2 * N_SOCK;

  logic            rst_q_n;
  logic [EV_W-1:0] ev_rise, ev_lat;
  logic            service;
  logic            card_level, core_level, wake_now, hold_now;

  ckrun_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ckrun_evt_latch #(.W(EV_W)) u_evt (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .evt     ({cbwake, stschg16}),
    .service (service),
    .rise    (ev_rise),
    .lat     (ev_lat)
  );

  always_comb begin
    card_level = (|ireq16) | (|cint) | (|cclk_req) | (|cbus_req);
    core_level = keep_clk | master_busy | post_pending | irq_pending | (|fifo_busy);
    wake_now   = card_level | core_level | (|ev_rise) | (|ev_lat);
    hold_now   = wake_now | (|cclk_running);
  end

  ckrun_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .line_n   (crun_line_n),
    .hold_now (hold_now),
    .wake_now (wake_now),
    .pull     (crun_pull),
    .service  (service)
  );
endmodule

// File: rtl/ckrun_keepalive_chk.sv
module ckrun_keepalive_chk #(
  parameter int N_FIFO = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_n,
  input logic              pull,
  input logic              keep_clk,
  input logic              master_busy,
  input logic              irq_pending,
  input logic [N_FIFO-1:0] fifo_busy
);
  // R2 / R6: a request lasts at least two cycles
  assert_pull_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |=> pull);

  // R6: a request never lasts longer than two cycles
  assert_pull_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && $past(pull)) |=> !pull);

  assert_keep_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pull && line_n && keep_clk && $past(keep_clk)) |=> pull);

  assert_busy_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pull && line_n && (master_busy || (|fifo_busy)) && $past(master_busy || (|fifo_busy))) |=> pull);

  assert_irq_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pull && line_n && irq_pending && $past(irq_pending)) |=> pull);

  assert_no_pull_line_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_n && !pull) |=> !pull);
endmodule

bind ckrun_keepalive ckrun_keepalive_chk #(.N_FIFO(N_FIFO)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .line_n      (crun_line_n),
  .pull        (crun_pull),
  .keep_clk    (keep_clk),
  .master_busy (master_busy),
  .irq_pending (irq_pending),
  .fifo_busy   (fifo_busy)
);

// File: tb/ckrun_keepalive_test.sv
module ckrun_keepalive_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int NF = 4;

  logic clk, rst_n;
  logic host_hold;
  logic crun_pull, crun_line_n;
  logic [NS-1:0] ireq16, cint, stschg16, cbwake, cclk_req, cbus_req, cclk_running;
  logic keep_clk, post_pending, master_busy, irq_pending;
  logic [NF-1:0] fifo_busy;

  int checks = 0;
  int failures = 0;

  assign crun_line_n = ~(host_hold | crun_pull);

  ckrun_keepalive #(.N_SOCK(NS), .N_FIFO(NF), .HOLD_CYC(2)) uut (
    .clk(clk), .rst_n(rst_n), .crun_line_n(crun_line_n), .crun_pull(crun_pull),
    .ireq16(ireq16), .cint(cint), .stschg16(stschg16), .cbwake(cbwake),
    .cclk_req(cclk_req), .cbus_req(cbus_req), .cclk_running(cclk_running),
    .keep_clk(keep_clk), .fifo_busy(fifo_busy), .post_pending(post_pending),
    .master_busy(master_busy), .irq_pending(irq_pending)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_wake();
    return (|ireq16) | (|cint) | (|cclk_req) | (|cbus_req) | keep_clk | master_busy |
           post_pending | irq_pending | (|fifo_busy) | (|stschg16) | (|cbwake);
  endfunction

  function automatic logic exp_hold();
    return exp_wake() | (|cclk_running);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: crun_pull=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic clear_inputs();
    ireq16 = '0; cint = '0; stschg16 = '0; cbwake = '0; cclk_req = '0;
    cbus_req = '0; cclk_running = '0; keep_clk = 0; fifo_busy = '0;
    post_pending = 0; master_busy = 0; irq_pending = 0;
  endtask

  // Stop request with activity already set: expect a two-cycle refusal
  task automatic expect_refuse(input string tag);
    host_hold = 0;
    step(); chk(crun_pull, 1'b1, tag);
    step(); chk(crun_pull, 1'b1, tag);
    host_hold = 1;
    step(); chk(crun_pull, 1'b0, tag);
  endtask

  // Stop request with nothing active: expect park
  task automatic expect_park(input string tag);
    host_hold = 0;
    step(); chk(crun_pull, 1'b0, tag);
    step(); chk(crun_pull, 1'b0, tag);
  endtask

  // Called while parked, right after wake inputs are set at a negedge
  task automatic expect_wake(input string tag);
    step(); chk(crun_pull, 1'b0, tag);
    step(); chk(crun_pull, 1'b1, tag);
    step(); chk(crun_pull, 1'b1, tag);
    host_hold = 1;
    step(); chk(crun_pull, 1'b0, tag);
  endtask

  task automatic settle();
    clear_inputs();
    host_hold = 1;
    repeat (3) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clear_inputs();
    host_hold = 1;
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();
    chk(crun_pull, 1'b0, "R1 reset");

    // R1: running state treats a released line as a stop request -> parks
    expect_park("R1 run state after reset");
    host_hold = 1; step(); settle();

    master_busy = 1; step(); expect_refuse("R2 master busy"); settle();
    post_pending = 1; step(); expect_refuse("R2 posted write"); settle();
    fifo_busy[NF-1] = 1; step(); expect_refuse("R2 fifo data"); settle();
    irq_pending = 1; step(); expect_refuse("R3 pending irq"); settle();
    cclk_running[1] = 1; step(); expect_refuse("R3 card clock running"); settle();
    keep_clk = 1; step(); expect_refuse("R4 keep_clk refuse"); settle();

    expect_park("R5 idle park");
    keep_clk = 1; expect_wake("R4 keep_clk wake"); settle();

    expect_park("R6 park");
    cbus_req[0] = 1; expect_wake("R6 bus request wake"); settle();
    expect_park("R6 park");
    ireq16[1] = 1; expect_wake("R6 16-bit irq wake"); settle();

    // R7: one-cycle wake pulse while parked
    expect_park("R7 park");
    cbwake[1] = 1; step(); cbwake[1] = 0;
    chk(crun_pull, 1'b0, "R7 pulse");
    step(); chk(crun_pull, 1'b1, "R7 pulse wake");
    step(); chk(crun_pull, 1'b1, "R7 pulse wake");
    host_hold = 1;
    step(); chk(crun_pull, 1'b0, "R7 pulse end");
    settle();

    // R8: event while running is latched, refused once, then cleared
    stschg16[0] = 1; step(); stschg16[0] = 0; repeat (3) step();
    chk(crun_pull, 1'b0, "R8 no pull while running");
    expect_refuse("R8 latched event refuses"); settle();
    expect_park("R8 latch cleared");
    host_hold = 1; step(); settle();

    // R9: card clock alone does not wake
    expect_park("R9 park");
    cclk_running = '1;
    step(); chk(crun_pull, 1'b0, "R9 no wake");
    step(); chk(crun_pull, 1'b0, "R9 no wake");
    step(); chk(crun_pull, 1'b0, "R9 no wake");
    settle();

    // R10 / R11: host restarts, then line held low with activity set
    expect_park("R10 park");
    host_hold = 1; master_busy = 1; cint[0] = 1;
    step(); chk(crun_pull, 1'b0, "R10 host restart");
    step(); chk(crun_pull, 1'b0, "R11 line low");
    step(); chk(crun_pull, 1'b0, "R11 line low");
    clear_inputs();
    step();
    expect_park("R10 back in run state"); settle();

    // Random trials
    for (int t = 0; t < 60; t++) begin
      ireq16 = NS'($urandom % 4) & NS'(($urandom % 6 == 0) ? '1 : '0);
      cint = (($urandom % 10) == 0) ? NS'(1) : '0;
      stschg16 = (($urandom % 10) == 0) ? NS'(2) : '0;
      cbwake = (($urandom % 10) == 0) ? NS'(1) : '0;
      cclk_req = (($urandom % 10) == 0) ? NS'(2) : '0;
      cbus_req = (($urandom % 12) == 0) ? NS'(1) : '0;
      cclk_running = (($urandom % 8) == 0) ? NS'(1) : '0;
      keep_clk = (($urandom % 14) == 0);
      fifo_busy = (($urandom % 10) == 0) ? NF'(1 << ($urandom % NF)) : '0;
      post_pending = (($urandom % 12) == 0);
      master_busy = (($urandom % 12) == 0);
      irq_pending = (($urandom % 12) == 0);
      if (exp_hold()) begin
        if ((t % 2) == 0) begin
          expect_refuse("R2 random refuse");
        end else begin
          expect_refuse("R3 random refuse");
        end
        settle();
        expect_park("R8 random latch cleared");
        host_hold = 1; step(); settle();
      end else begin
        expect_park("R5 random park");
        case ($urandom % 5)
          0: cint[1] = 1;
          1: cbwake[0] = 1;
          2: post_pending = 1;
          3: cclk_req[1] = 1;
          default: cclk_running[0] = 1;
        endcase
        if (exp_wake()) begin
          expect_wake("R6 random wake");
        end else begin
          step(); chk(crun_pull, 1'b0, "R9 random no wake");
          step(); chk(crun_pull, 1'b0, "R9 random no wake");
          host_hold = 1;
          step(); chk(crun_pull, 1'b0, "R10 random restart");
        end
        settle();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule